// File: doc/BRIEF.md
# DMA Block Copy Engine

This block is the transfer engine of one DMA channel. A register bank pulses `start` and presents the channel's pending descriptor: a configuration word, a byte count, a destination address and a source address. The engine checks the descriptor in the same cycle. If the descriptor is rejected, the engine raises its error flag and does nothing else. If it is accepted, the engine loads its working (exec) registers and copies the region as a series of equal-size transactions.

Each transaction is first read into a 64-byte staging buffer over a valid/ready request port. Read data returns on a separate response strobe. The buffered data is then written back out to the destination. The engine keeps its remaining byte count and its current source and destination pointers visible throughout the transfer. When the copy ends, it reports completion to the register bank: a done flag and a one-cycle pulse that tells the bank to drop its run bit.

The configuration word has these fields. Bits 31:28 hold the read size, as log2 of bytes. Bits 27:24 hold the write size, in the same form. Bit 2 is the repeat control. The transaction size is 2 raised to the size field, with the field clamped at 6. A transaction moves as beats of min(transaction size, DATA_W/8) bytes. The data of a narrower beat sits in the low byte lanes.

Top module: `dma_cpy_engine`

## Requirements
- R1: A start with a byte count of zero sets `flag_err` one cycle later, issues no memory request, and leaves the exec registers unchanged.
- R2: A start whose read size field (bits 31:28) differs from its write size field (bits 27:24) is rejected in the same way as R1.
- R3: The transaction size is 2^min(size field, 6) bytes. Each beat carries min(transaction size, DATA_W/8) bytes. `mem_req_size` gives log2 of the beat's byte count, and `mem_req_addr` steps by that many bytes from beat to beat.
- R4: A start whose byte count is not a multiple of the transaction size is rejected in the same way as R1.
- R5: One cycle after an accepted start, `busy` is high, `flag_done` and `flag_err` are low, and `exec_cfg`, `exec_bytes`, `exec_dst` and `exec_src` hold the values the descriptor presented.
- R6: The engine copies the region in transactions of ascending address. After the last write of each transaction, `exec_src` and `exec_dst` grow by the transaction size and `exec_bytes` falls by the same amount. No request is issued while `busy` is low.
- R7: In the cycle after the final write is accepted, `busy` falls, `flag_done` rises, and `run_clr` pulses high for exactly one cycle.
- R8: With the repeat bit (bit 2) set, completion leaves `exec_bytes`, `exec_dst` and `exec_src` at their starting values. Without it, these registers end at 0, dst+bytes and src+bytes.
- R9: A rejected start sets only `flag_err`. `flag_done` keeps its value, and `run_clr` does not pulse.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, direction, size and write data do not change.
- R11: A start that arrives while `busy` is high is ignored. The exec registers, the flags and the transfer in flight are unaffected.
- R12: Every read beat of a transaction receives its response before the first write beat of that transaction is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse from the register bank |
| nxt_cfg | input | 32 | Pending configuration word |
| nxt_bytes | input | CNT_W | Pending byte count |
| nxt_dst | input | ADDR_W | Pending destination address |
| nxt_src | input | ADDR_W | Pending source address |
| busy | output | 1 | Transfer in progress |
| flag_done | output | 1 | Completion flag |
| flag_err | output | 1 | Rejected-descriptor flag |
| run_clr | output | 1 | One-cycle request to clear the run bit |
| exec_cfg | output | 32 | Configuration of the current transfer |
| exec_bytes | output | CNT_W | Remaining byte count |
| exec_dst | output | ADDR_W | Current destination address |
| exec_src | output | ADDR_W | Current source address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_req_addr | output | ADDR_W | Beat byte address |
| mem_req_size | output | 3 | log2 of beat byte count |
| mem_req_wdata | output | DATA_W | Write data, low lanes used |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | DATA_W | Read response data |

## Verification
The outcome of a start appears one clock after the edge that samples it: the error flag, or the cleared flags together with the loaded exec registers. The bench drives `start` at a falling edge and checks these results at the next falling edge. Completion appears one clock after the edge that accepts the final write: `busy` falls and `flag_done` and `run_clr` rise. The bench waits for `busy` to fall and checks at that falling edge. It then checks that `run_clr` is low one falling edge later.

Memory requests are checked at the rising edge where the handshake happens, against a queue of the reads and writes expected from the descriptor. The order in that queue is what checks R12.

// File: rtl/dma_cpy_pkg.sv
package dma_cpy_pkg;

  localparam int CFG_REP_BIT = 2;
  localparam int CFG_WSZ_LSB = 24;
  localparam int CFG_RSZ_LSB = 28;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RWAIT,
    ST_WLD,
    ST_WR
  } seq_st_t;

endpackage

// File: rtl/dma_cpy_vet.sv
module dma_cpy_vet #(
  parameter int CNT_W   = 32,
  parameter int MAX_LOG = 6
) (
  input  logic [7:0]       sz_fields,
  input  logic [CNT_W-1:0] bytes,
  output logic             ok,
  output logic [2:0]       sz_clamped
);

  logic [3:0]       wsz;
  logic [3:0]       rsz;
  logic [CNT_W-1:0] mask;

  always_comb begin
    wsz = sz_fields[3:0];
    rsz = sz_fields[7:4];
    if (wsz > 4'(MAX_LOG)) sz_clamped = 3'(MAX_LOG);
    else                   sz_clamped = wsz[2:0];
    mask = (CNT_W'(1) << sz_clamped) - CNT_W'(1);
    ok   = (bytes != '0) && (wsz == rsz) && ((bytes & mask) == '0);
  end

endmodule

// File: rtl/dma_cpy_stage.sv
module dma_cpy_stage #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  parameter int IW     = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/dma_cpy_seq.sv
module dma_cpy_seq
  import dma_cpy_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 32,
  parameter int DATA_W   = 64,
  parameter int LOG_BEAT = 3,
  parameter int IW       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       nxt_cfg,
  input  logic [CNT_W-1:0]  nxt_bytes,
  input  logic [ADDR_W-1:0] nxt_dst,
  input  logic [ADDR_W-1:0] nxt_src,
  input  logic              vet_ok,
  input  logic [2:0]        vet_sz,
  output logic              busy,
  output logic              flag_done,
  output logic              flag_err,
  output logic              run_clr,
  output logic [31:0]       exec_cfg,
  output logic [CNT_W-1:0]  exec_bytes,
  output logic [ADDR_W-1:0] exec_dst,
  output logic [ADDR_W-1:0] exec_src,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [2:0]        mem_req_size,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              buf_wr_en,
  output logic [IW-1:0]     buf_wr_idx,
  output logic [DATA_W-1:0] buf_wr_data,
  output logic              buf_rd_en,
  output logic [IW-1:0]     buf_rd_idx
);

  seq_st_t           st;
  logic [2:0]        sz_q;
  logic [2:0]        lb_q;
  logic [IW-1:0]     beat_q;
  logic [IW-1:0]     last_beat;
  logic              rep_q;
  logic [ADDR_W-1:0] rd_ptr;
  logic [ADDR_W-1:0] wr_ptr;
  logic [CNT_W-1:0]  org_bytes;
  logic [ADDR_W-1:0] org_dst;
  logic [ADDR_W-1:0] org_src;
  logic [2:0]        lb_start;
  logic [6:0]        span;
  logic [ADDR_W-1:0] beat_b;
  logic [ADDR_W-1:0] txn_a;
  logic [CNT_W-1:0]  txn_c;
  logic              last_txn;

  always_comb begin
    if (vet_sz > 3'(LOG_BEAT)) lb_start = 3'(LOG_BEAT);
    else                       lb_start = vet_sz;
    span      = 7'd1 << (sz_q - lb_q);
    last_beat = IW'(span - 7'd1);
    beat_b    = ADDR_W'(1) << lb_q;
    txn_a     = ADDR_W'(1) << sz_q;
    txn_c     = CNT_W'(1) << sz_q;
    last_txn  = (exec_bytes == txn_c);
  end

  always_comb begin
    mem_req_valid = (st == ST_RD) || (st == ST_WR);
    mem_req_write = (st == ST_WR);
    mem_req_addr  = (st == ST_WR) ? wr_ptr : rd_ptr;
    mem_req_size  = lb_q;
    buf_wr_en     = (st == ST_RWAIT) && mem_rsp_valid;
    buf_wr_idx    = beat_q;
    buf_wr_data   = mem_rsp_rdata;
    buf_rd_en     = (st == ST_WLD);
    buf_rd_idx    = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      busy       <= 1'b0;
      flag_done  <= 1'b0;
      flag_err   <= 1'b0;
      run_clr    <= 1'b0;
      exec_cfg   <= '0;
      exec_bytes <= '0;
      exec_dst   <= '0;
      exec_src   <= '0;
      org_bytes  <= '0;
      org_dst    <= '0;
      org_src    <= '0;
      rep_q      <= 1'b0;
      sz_q       <= '0;
      lb_q       <= '0;
      beat_q     <= '0;
      rd_ptr     <= '0;
      wr_ptr     <= '0;
    end else begin
      run_clr <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (vet_ok) begin
              flag_done  <= 1'b0;
              flag_err   <= 1'b0;
              exec_cfg   <= nxt_cfg;
              exec_bytes <= nxt_bytes;
              exec_dst   <= nxt_dst;
              exec_src   <= nxt_src;
              org_bytes  <= nxt_bytes;
              org_dst    <= nxt_dst;
              org_src    <= nxt_src;
              rep_q      <= nxt_cfg[CFG_REP_BIT];
              sz_q       <= vet_sz;
              lb_q       <= lb_start;
              rd_ptr     <= nxt_src;
              wr_ptr     <= nxt_dst;
              beat_q     <= '0;
              busy       <= 1'b1;
              st         <= ST_RD;
            end else begin
              flag_err <= 1'b1;
            end
          end
        end
        ST_RD: begin
          if (mem_req_ready) begin
            rd_ptr <= rd_ptr + beat_b;
            st     <= ST_RWAIT;
          end
        end
        ST_RWAIT: begin
          if (mem_rsp_valid) begin
            if (beat_q == last_beat) begin
              beat_q <= '0;
              st     <= ST_WLD;
            end else begin
              beat_q <= beat_q + IW'(1);
              st     <= ST_RD;
            end
          end
        end
        ST_WLD: begin
          st <= ST_WR;
        end
        ST_WR: begin
          if (mem_req_ready) begin
            wr_ptr <= wr_ptr + beat_b;
            if (beat_q == last_beat) begin
              beat_q     <= '0;
              exec_src   <= exec_src + txn_a;
              exec_dst   <= exec_dst + txn_a;
              exec_bytes <= exec_bytes - txn_c;
              if (last_txn) begin
                busy      <= 1'b0;
                flag_done <= 1'b1;
                run_clr   <= 1'b1;
                st        <= ST_IDLE;
                if (rep_q) begin
                  exec_bytes <= org_bytes;
                  exec_dst   <= org_dst;
                  exec_src   <= org_src;
                end
              end else begin
                st <= ST_RD;
              end
            end else begin
              beat_q <= beat_q + IW'(1);
              st     <= ST_WLD;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_cpy_engine.sv
module dma_cpy_engine #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 64,
  parameter int MAX_LOG = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       nxt_cfg,
  input  logic [CNT_W-1:0]  nxt_bytes,
  input  logic [ADDR_W-1:0] nxt_dst,
  input  logic [ADDR_W-1:0] nxt_src,
  output logic              busy,
  output logic              flag_done,
  output logic              flag_err,
  output logic              run_clr,
  output logic [31:0]       exec_cfg,
  output logic [CNT_W-1:0]  exec_bytes,
  output logic [ADDR_W-1:0] exec_dst,
  output logic [ADDR_W-1:0] exec_src,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [2:0]        mem_req_size,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);

  localparam int BEAT_B   = DATA_W / 8;
  localparam int LOG_BEAT = $clog2(BEAT_B);
  localparam int DEPTH    = (1 << MAX_LOG) / BEAT_B;
  localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              vet_ok;
  logic [2:0]        vet_sz;
  logic              buf_wr_en;
  logic [IW-1:0]     buf_wr_idx;
  logic [DATA_W-1:0] buf_wr_data;
  logic              buf_rd_en;
  logic [IW-1:0]     buf_rd_idx;

  dma_cpy_vet #(
    .CNT_W  (CNT_W),
    .MAX_LOG(MAX_LOG)
  ) u_vet (
    .sz_fields (nxt_cfg[31:24]),
    .bytes     (nxt_bytes),
    .ok        (vet_ok),
    .sz_clamped(vet_sz)
  );

  dma_cpy_stage #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .IW    (IW)
  ) u_stage (
    .clk    (clk),
    .wr_en  (buf_wr_en),
    .wr_idx (buf_wr_idx),
    .wr_data(buf_wr_data),
    .rd_en  (buf_rd_en),
    .rd_idx (buf_rd_idx),
    .rd_data(mem_req_wdata)
  );

  dma_cpy_seq #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .DATA_W  (DATA_W),
    .LOG_BEAT(LOG_BEAT),
    .IW      (IW)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .nxt_cfg      (nxt_cfg),
    .nxt_bytes    (nxt_bytes),
    .nxt_dst      (nxt_dst),
    .nxt_src      (nxt_src),
    .vet_ok       (vet_ok),
    .vet_sz       (vet_sz),
    .busy         (busy),
    .flag_done    (flag_done),
    .flag_err     (flag_err),
    .run_clr      (run_clr),
    .exec_cfg     (exec_cfg),
    .exec_bytes   (exec_bytes),
    .exec_dst     (exec_dst),
    .exec_src     (exec_src),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_size (mem_req_size),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata),
    .buf_wr_en    (buf_wr_en),
    .buf_wr_idx   (buf_wr_idx),
    .buf_wr_data  (buf_wr_data),
    .buf_rd_en    (buf_rd_en),
    .buf_rd_idx   (buf_rd_idx)
  );

endmodule

// File: rtl/dma_cpy_sva.sv
module dma_cpy_sva #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [7:0]        nxt_sz,
  input logic [CNT_W-1:0]  nxt_bytes,
  input logic              busy,
  input logic              flag_done,
  input logic              flag_err,
  input logic              run_clr,
  input logic [31:0]       exec_cfg,
  input logic [CNT_W-1:0]  exec_bytes,
  input logic [ADDR_W-1:0] exec_dst,
  input logic [ADDR_W-1:0] exec_src,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [2:0]        mem_req_size,
  input logic [DATA_W-1:0] mem_req_wdata
);

  AST_ZERO_LEN_ERR: assert property (@(posedge clk) disable iff (rst)
    start && !busy && (nxt_bytes == '0) |=> flag_err && !busy); // R1

  AST_SIZE_MISMATCH_ERR: assert property (@(posedge clk) disable iff (rst)
    start && !busy && (nxt_sz[7:4] != nxt_sz[3:0]) |=> flag_err && !busy); // R2

  AST_START_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !flag_done && !flag_err); // R5

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) && (exec_bytes != $past(exec_bytes)) |->
      ((exec_src - $past(exec_src)) == ADDR_W'($past(exec_bytes) - exec_bytes)) &&
      ((exec_dst - $past(exec_dst)) == ADDR_W'($past(exec_bytes) - exec_bytes))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid); // R6

  AST_RUN_CLR_DONE: assert property (@(posedge clk) disable iff (rst)
    run_clr |-> flag_done && !flag_err && !busy); // R7

  AST_RUN_CLR_PULSE: assert property (@(posedge clk) disable iff (rst)
    run_clr |=> !run_clr); // R7

  AST_ERR_KEEPS_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_err) |-> (flag_done == $past(flag_done)) && !run_clr); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_write) && $stable(mem_req_size) &&
      (!mem_req_write || $stable(mem_req_wdata))); // R10

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(exec_cfg) && !flag_err); // R11

endmodule

bind dma_cpy_engine dma_cpy_sva #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W),
  .DATA_W(DATA_W)
) u_sva (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .nxt_sz       (nxt_cfg[31:24]),
  .nxt_bytes    (nxt_bytes),
  .busy         (busy),
  .flag_done    (flag_done),
  .flag_err     (flag_err),
  .run_clr      (run_clr),
  .exec_cfg     (exec_cfg),
  .exec_bytes   (exec_bytes),
  .exec_dst     (exec_dst),
  .exec_src     (exec_src),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr),
  .mem_req_size (mem_req_size),
  .mem_req_wdata(mem_req_wdata)
);

// File: tb/dma_cpy_engine_test.sv
`timescale 1ns/1ps
module dma_cpy_engine_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] nxt_cfg = '0;
  logic [31:0] nxt_bytes = '0;
  logic [31:0] nxt_dst = '0;
  logic [31:0] nxt_src = '0;
  logic        busy, flag_done, flag_err, run_clr;
  logic [31:0] exec_cfg, exec_bytes, exec_dst, exec_src;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [2:0]  mem_req_size;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;

  always #10 clk = ~clk;

  dma_cpy_engine uut (
    .clk(clk), .rst(rst), .start(start), .nxt_cfg(nxt_cfg), .nxt_bytes(nxt_bytes),
    .nxt_dst(nxt_dst), .nxt_src(nxt_src), .busy(busy), .flag_done(flag_done),
    .flag_err(flag_err), .run_clr(run_clr), .exec_cfg(exec_cfg), .exec_bytes(exec_bytes),
    .exec_dst(exec_dst), .exec_src(exec_src), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  typedef struct {
    bit          wr;
    int unsigned addr;
    int unsigned lsz;
    logic [63:0] data;
  } exp_t;

  exp_t        exp_q[$];
  int unsigned pend_q[$];
  logic [7:0]  mem [4096];
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_word(input int unsigned a);
    logic [63:0] w;
    for (int i = 0; i < 8; i++) w[8*i +: 8] = mem[(a + i) % 4096];
    return w;
  endfunction

  // Request monitor: handshakes sampled at the rising edge
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
    if (!rst) begin
      if (mem_req_valid && mem_req_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected request addr", mem_req_addr, 0);
        end else begin
          exp_t e;
          logic [63:0] m;
          e = exp_q.pop_front();
          m = (e.lsz >= 3) ? '1 : ((64'd1 << (8 << e.lsz)) - 64'd1);
          chk(mem_req_write == e.wr, "R12", "request direction", mem_req_write, e.wr);
          chk(mem_req_addr == e.addr, "R6", "request address", mem_req_addr, e.addr);
          chk(mem_req_size == 3'(e.lsz), "R3", "request size", mem_req_size, e.lsz);
          if (e.wr)
            chk((mem_req_wdata & m) == (e.data & m), "R6", "write data",
                mem_req_wdata & m, e.data & m);
        end
        if (mem_req_write) begin
          for (int i = 0; i < (1 << mem_req_size); i++)
            mem[(mem_req_addr + i) % 4096] = mem_req_wdata[8*i +: 8];
        end else begin
          pend_q.push_back(mem_req_addr);
        end
      end
      if (mem_rsp_valid && pend_q.size() > 0) void'(pend_q.pop_front());
    end
  end

  // Memory responder, driven at the falling edge
  always @(negedge clk) begin
    mem_req_ready = ($urandom % 4) != 0;
    if (pend_q.size() > 0 && ($urandom % 3) != 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_rdata = mem_word(pend_q[0]);
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_rdata = {$urandom, $urandom};
    end
  end

  function automatic logic [31:0] mk_cfg(input int rs, input int ws, input bit rep);
    return (32'(rs) << 28) | (32'(ws) << 24) | (32'(rep) << 2);
  endfunction

  task automatic run_desc(input logic [31:0] cfg, input int unsigned bytes,
                          input int unsigned dst, input int unsigned src,
                          input bit ok_exp, input bit poke, input string tag);
    logic [7:0]  snap [$];
    bit          pdone;
    logic [31:0] pcfg, pbytes;
    int          ws, sz, tb, bb, nbt, n;
    int          bad;
    bit          rep;
    ws  = int'(cfg[27:24]);
    sz  = (ws > 6) ? 6 : ws;
    tb  = 1 << sz;
    bb  = (tb > 8) ? 8 : tb;
    nbt = tb / bb;
    rep = cfg[2];
    for (int i = 0; i < int'(bytes); i++) begin
      mem[(src + i) % 4096] = 8'((src + i) * 7 + bytes);
      snap.push_back(mem[(src + i) % 4096]);
    end
    if (ok_exp) begin
      for (int t = 0; t < int'(bytes) / tb; t++) begin
        for (int b = 0; b < nbt; b++)
          exp_q.push_back('{1'b0, src + t * tb + b * bb, $clog2(bb), 64'd0});
        for (int b = 0; b < nbt; b++) begin
          logic [63:0] d = '0;
          for (int k = 0; k < bb; k++) d[8*k +: 8] = snap[t * tb + b * bb + k];
          exp_q.push_back('{1'b1, dst + t * tb + b * bb, $clog2(bb), d});
        end
      end
    end
    pdone  = flag_done;
    pcfg   = exec_cfg;
    pbytes = exec_bytes;
    @(negedge clk);
    nxt_cfg = cfg; nxt_bytes = bytes; nxt_dst = dst; nxt_src = src; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!ok_exp) begin
      chk(flag_err == 1'b1, tag, "error flag", flag_err, 1);
      chk(busy == 1'b0, tag, "busy after reject", busy, 0);
      chk(flag_done == pdone, "R9", "done kept on error", flag_done, pdone);
      chk(run_clr == 1'b0, "R9", "no run_clr on error", run_clr, 0);
      chk(exec_cfg == pcfg && exec_bytes == pbytes, "R1", "exec unchanged", exec_bytes, pbytes);
      chk(!mem_req_valid, "R1", "no request on error", mem_req_valid, 0);
      return;
    end
    chk(busy == 1'b1, "R5", "busy after start", busy, 1);
    chk(!flag_done && !flag_err, "R5", "flags cleared", {flag_done, flag_err}, 0);
    chk(exec_cfg == cfg, "R5", "exec_cfg loaded", exec_cfg, cfg);
    chk(exec_bytes == bytes, "R5", "exec_bytes loaded", exec_bytes, bytes);
    chk(exec_src == src && exec_dst == dst, "R5", "exec addresses loaded", exec_src, src);
    if (poke) begin
      nxt_cfg = mk_cfg(1, 1, 1'b0); nxt_bytes = 0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(exec_cfg == cfg, "R11", "exec_cfg after busy start", exec_cfg, cfg);
      chk(flag_err == 1'b0, "R11", "no error from busy start", flag_err, 0);
    end
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(run_clr == 1'b1, "R7", "run_clr at completion", run_clr, 1);
    chk(flag_done == 1'b1 && flag_err == 1'b0, "R7", "done flag", flag_done, 1);
    chk(exp_q.size() == 0, "R6", "requests outstanding", exp_q.size(), 0);
    if (rep) begin
      chk(exec_bytes == bytes, "R8", "repeat reload bytes", exec_bytes, bytes);
      chk(exec_src == src && exec_dst == dst, "R8", "repeat reload src", exec_src, src);
    end else begin
      chk(exec_bytes == 0, "R8", "final bytes", exec_bytes, 0);
      chk(exec_src == src + bytes && exec_dst == dst + bytes, "R8", "final src", exec_src,
          src + bytes);
    end
    bad = 0;
    for (int i = 0; i < int'(bytes); i++)
      if (mem[(dst + i) % 4096] != snap[i]) bad++;
    chk(bad == 0, tag, "destination bytes wrong", bad, 0);
    @(negedge clk);
    chk(run_clr == 1'b0, "R7", "run_clr one cycle", run_clr, 0);
    exp_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 13);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !flag_done && !flag_err && !run_clr, "R5", "reset flags",
        {busy, flag_done, flag_err, run_clr}, 0);
    chk(exec_bytes == 0 && exec_src == 0 && !mem_req_valid, "R6", "reset exec", exec_bytes, 0);
    run_desc(mk_cfg(3, 3, 0), 0,   'h800, 'h100, 1'b0, 1'b0, "R1");
    run_desc(mk_cfg(3, 3, 0), 32,  'h800, 'h100, 1'b1, 1'b0, "R6");
    run_desc(mk_cfg(3, 2, 0), 16,  'h800, 'h100, 1'b0, 1'b0, "R2");
    run_desc(mk_cfg(6, 6, 0), 128, 'h900, 'h200, 1'b1, 1'b0, "R3");
    run_desc(mk_cfg(1, 1, 0), 6,   'hA00, 'h300, 1'b1, 1'b0, "R3");
    run_desc(mk_cfg(3, 3, 0), 12,  'h800, 'h100, 1'b0, 1'b0, "R4");
    run_desc(mk_cfg(9, 9, 0), 32,  'h800, 'h100, 1'b0, 1'b0, "R4");
    run_desc(mk_cfg(9, 9, 0), 64,  'hB00, 'h400, 1'b1, 1'b0, "R3");
    run_desc(mk_cfg(4, 4, 1), 48,  'hC00, 'h500, 1'b1, 1'b0, "R8");
    run_desc(mk_cfg(0, 0, 0), 5,   'hD00, 'h600, 1'b1, 1'b1, "R11");
    run_desc(mk_cfg(5, 5, 0), 96,  'hE00, 'h700, 1'b1, 1'b0, "R12");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule